// File: doc/BRIEF.md
# Per-Channel Conversion Trigger Router

This block sits in front of a multi-channel analog-to-digital converter and decides, for each of seven analog channels, which event starts a conversion on that channel. A 32-bit configuration word holds one 4-bit source code per channel. The possible sources are a global software trigger that clears itself, a level software trigger, a scan trigger gated by a per-channel mask, a synchronous trigger, and eleven event-system lines. Each cycle the block turns the active sources into per-channel start pulses and presents them on a registered output vector.

Software reads and writes the configuration word over a simple single-register bus. Writes are refused with an error response while the converter is enabled. A control mode (software conversion enabled together with core-select value 1) overrides every selector so that no channel is started from this word. Edge-type sources produce exactly one start pulse per rising edge. The level software trigger keeps its channels asserted for as long as it is held.

Top module: `adc_trig_router`

## Requirements
- R1: After reset the configuration word reads 0x00000019, every channel start output is 0, the global trigger pending flag is 0 and the bus error output is 0.
- R2: A write while `conv_enable` is 0 stores the data and is visible on `bus_rdata` in the next cycle. Bits 31:28 always read 0, and channel k uses bits [4k+3:4k]. No error is returned.
- R3: A write while `conv_enable` is 1 leaves the word unchanged, and `bus_err` is 1 for exactly the cycle after the access.
- R4: A channel with code 0 never produces a start pulse.
- R5: Code 1 follows the global software trigger. A `gsw_set` pulse raises `gsw_pending` in the next cycle. In the cycle after that, every channel with code 1 shows a one-cycle start and `gsw_pending` returns to 0, whether or not any channel selects code 1.
- R6: Code 2 follows `lsw_level`. The channel start is 1 in every cycle that follows a cycle in which `lsw_level` is 1.
- R7: Code 3 follows a rising edge of `scan_trig`, but only on channels whose bit in `scan_mask` is 1.
- R8: Code 4 follows a rising edge of `sync_trig`.
- R9: Codes 5 to 15 follow a rising edge of `evt_in[code-5]`, and only while `event_start_en` is 1.
- R10: While `sw_conv_en` is 1 and `core_sel` equals 1, no channel start is produced, whatever the selectors are.
- R11: Every edge-type source (scan, sync, event) gives a single one-cycle start per rising edge, even if the input is held high.
- R12: A selector write takes effect from the following cycle. A trigger that arrives in the same cycle as the write is routed by the previous selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current configuration word |
| bus_err | output | 1 | Error response for a refused write, one cycle after the access |
| conv_enable | input | 1 | Converter enabled; locks the configuration word |
| sw_conv_en | input | 1 | Software conversion mode bit |
| core_sel | input | 2 | Core select field; with `sw_conv_en`, value 1 overrides routing |
| event_start_en | input | 1 | Allows event-line triggers |
| scan_mask | input | 7 | Per-channel scan inclusion mask |
| gsw_set | input | 1 | Software sets the global one-shot trigger bit |
| lsw_level | input | 1 | Level software trigger bit |
| scan_trig | input | 1 | Scan trigger input |
| sync_trig | input | 1 | Synchronous trigger input |
| evt_in | input | 11 | Event-system trigger lines |
| gsw_pending | output | 1 | Global trigger bit, cleared by hardware |
| chan_start | output | 7 | Per-channel start-of-conversion outputs |

## Verification
A configuration write and a trigger edge can land in the same cycle. In that case the routing must use the selector that was in force before the write. The bench provokes this by writing a synchronous-trigger code to channel 0 in the same cycle that `sync_trig` rises. It then expects no start, because the old code was 0, and the new word is expected on the read port. Because the edge was consumed in that cycle, the bench also expects no later start while the input stays high.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE = 4'd0,
        SRC_GSW  = 4'd1,
        SRC_LSW  = 4'd2,
        SRC_SCAN = 4'd3,
        SRC_SYNC = 4'd4,
        SRC_EVT0 = 4'd5
    } trig_src_e;

    localparam int EVT_BASE = 5;

    localparam logic [1:0] CORE_SEL_OVERRIDE = 2'd1;

endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg #(
    parameter int              DATA_W    = 32,
    parameter int              NUM_CH    = 7,
    parameter int              SEL_W     = 4,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_0019
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              locked,
    output logic [DATA_W-1:0] cfg_o,
    output logic              err_o
);

    localparam int USED_W = NUM_CH * SEL_W;
    localparam logic [DATA_W-1:0] USED_MASK = (DATA_W'(1) << USED_W) - DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              err;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr_req) begin
            if (locked) begin
                st_d.err = 1'b1;
            end else begin
                st_d.cfg = wdata & USED_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= RESET_VAL & USED_MASK;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = st_q.cfg;
    assign err_o = st_q.err;

endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = lvl_i & ~st_q.prev;

endmodule

// File: rtl/trig_chan_sel.sv
module trig_chan_sel
    import adc_trig_pkg::*;
#(
    parameter int NUM_EVT = 11
) (
    input  logic [SEL_W-1:0]   code_i,
    input  logic               gsw_i,
    input  logic               lsw_i,
    input  logic               scan_rise_i,
    input  logic               scan_mask_i,
    input  logic               sync_rise_i,
    input  logic [NUM_EVT-1:0] evt_rise_i,
    input  logic               evt_en_i,
    output logic               hit_o
);

    always_comb begin
        hit_o = 1'b0;
        unique case (code_i)
            SRC_NONE: hit_o = 1'b0;
            SRC_GSW:  hit_o = gsw_i;
            SRC_LSW:  hit_o = lsw_i;
            SRC_SCAN: hit_o = scan_rise_i & scan_mask_i;
            SRC_SYNC: hit_o = sync_rise_i;
            default: begin
                for (int e = 0; e < NUM_EVT; e++) begin
                    if (int'(code_i) == EVT_BASE + e) begin
                        hit_o = evt_en_i & evt_rise_i[e];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/adc_trig_router.sv
module adc_trig_router
    import adc_trig_pkg::*;
#(
    parameter int              NUM_CH    = 7,
    parameter int              NUM_EVT   = 11,
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_0019
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic               conv_enable,
    input  logic               sw_conv_en,
    input  logic [1:0]         core_sel,
    input  logic               event_start_en,
    input  logic [NUM_CH-1:0]  scan_mask,
    input  logic               gsw_set,
    input  logic               lsw_level,
    input  logic               scan_trig,
    input  logic               sync_trig,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               gsw_pending,
    output logic [NUM_CH-1:0]  chan_start
);

    localparam int EDGE_W = NUM_EVT + 2;

    logic [DATA_W-1:0] cfg;
    logic [EDGE_W-1:0] rise;
    logic [NUM_CH-1:0] hit;
    logic              override;

    typedef struct packed {
        logic [NUM_CH-1:0] start;
        logic              gsw;
    } top_st_t;

    top_st_t st_d, st_q;

    trig_cfg_reg #(
        .DATA_W    (DATA_W),
        .NUM_CH    (NUM_CH),
        .SEL_W     (SEL_W),
        .RESET_VAL (RESET_VAL)
    ) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (bus_valid & bus_write),
        .wdata  (bus_wdata),
        .locked (conv_enable),
        .cfg_o  (cfg),
        .err_o  (bus_err)
    );

    trig_edge_det #(
        .W (EDGE_W)
    ) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({evt_in, sync_trig, scan_trig}),
        .rise_o (rise)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        trig_chan_sel #(
            .NUM_EVT (NUM_EVT)
        ) sel_i (
            .code_i      (cfg[k*SEL_W +: SEL_W]),
            .gsw_i       (st_q.gsw),
            .lsw_i       (lsw_level),
            .scan_rise_i (rise[0]),
            .scan_mask_i (scan_mask[k]),
            .sync_rise_i (rise[1]),
            .evt_rise_i  (rise[EDGE_W-1:2]),
            .evt_en_i    (event_start_en),
            .hit_o       (hit[k])
        );
    end

    assign override = sw_conv_en && (core_sel == CORE_SEL_OVERRIDE);

    always_comb begin
        st_d       = st_q;
        st_d.start = override ? '0 : hit;
        st_d.gsw   = gsw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.start <= '0;
            st_q.gsw   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata   = cfg;
    assign gsw_pending = st_q.gsw;
    assign chan_start  = st_q.start;

endmodule

// File: rtl/adc_trig_router_chk.sv
module adc_trig_router_chk #(
    parameter int NUM_CH  = 7,
    parameter int NUM_EVT = 11,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_err,
    input logic               conv_enable,
    input logic               sw_conv_en,
    input logic [1:0]         core_sel,
    input logic               gsw_set,
    input logic               gsw_pending,
    input logic [NUM_CH-1:0]  chan_start
);

    localparam int USED_W = NUM_CH * 4;

    a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:USED_W] == '0);

    a_r3_locked_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && conv_enable) |=> (bus_err && $stable(bus_rdata)));

    a_r3_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid && bus_write && conv_enable));

    a_r5_gsw_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (gsw_pending && !gsw_set) |=> !gsw_pending);

    a_r10_override_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_conv_en && core_sel == 2'd1) |=> (chan_start == '0));

    for (genvar k = 0; k < NUM_CH; k++) begin : g_zero
        a_r4_code_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rdata[k*4 +: 4] == 4'd0) |=> !chan_start[k]);
    end

endmodule

bind adc_trig_router adc_trig_router_chk #(
    .NUM_CH  (NUM_CH),
    .NUM_EVT (NUM_EVT),
    .DATA_W  (DATA_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_rdata   (bus_rdata),
    .bus_err     (bus_err),
    .conv_enable (conv_enable),
    .sw_conv_en  (sw_conv_en),
    .core_sel    (core_sel),
    .gsw_set     (gsw_set),
    .gsw_pending (gsw_pending),
    .chan_start  (chan_start)
);

// File: tb/adc_trig_router_tb_top.sv
module adc_trig_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        conv_enable = 1'b0;
    logic        sw_conv_en = 1'b0;
    logic [1:0]  core_sel = 2'd0;
    logic        event_start_en = 1'b0;
    logic [6:0]  scan_mask = '0;
    logic        gsw_set = 1'b0;
    logic        lsw_level = 1'b0;
    logic        scan_trig = 1'b0;
    logic        sync_trig = 1'b0;
    logic [10:0] evt_in = '0;
    logic        gsw_pending;
    logic [6:0]  chan_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_trig_router dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_valid      (bus_valid),
        .bus_write      (bus_write),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .bus_err        (bus_err),
        .conv_enable    (conv_enable),
        .sw_conv_en     (sw_conv_en),
        .core_sel       (core_sel),
        .event_start_en (event_start_en),
        .scan_mask      (scan_mask),
        .gsw_set        (gsw_set),
        .lsw_level      (lsw_level),
        .scan_trig      (scan_trig),
        .sync_trig      (sync_trig),
        .evt_in         (evt_in),
        .gsw_pending    (gsw_pending),
        .chan_start     (chan_start)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(logic [31:0] data);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "cfg", bus_rdata, 32'h19);
        check("R1", "start", 32'(chan_start), 0);
        check("R1", "pending", 32'(gsw_pending), 0);
        check("R1", "err", 32'(bus_err), 0);
    endtask

    task automatic t_write();
        bus_wr(32'hFFFF_FFFF);
        check("R2", "cfg top bits zero", bus_rdata, 32'h0FFF_FFFF);
        check("R2", "no err", 32'(bus_err), 0);
    endtask

    task automatic t_locked();
        conv_enable = 1'b1;
        bus_wr(32'h1234_5678);
        check("R3", "err", 32'(bus_err), 1);
        check("R3", "cfg kept", bus_rdata, 32'h0FFF_FFFF);
        @(negedge clk);
        check("R3", "err one cycle", 32'(bus_err), 0);
        conv_enable = 1'b0;
    endtask

    task automatic t_gsw();
        bus_wr(32'h0000_2101);
        gsw_set = 1'b1;
        @(negedge clk);
        gsw_set = 1'b0;
        check("R5", "pending set", 32'(gsw_pending), 1);
        check("R5", "no start yet", 32'(chan_start), 0);
        @(negedge clk);
        check("R5", "code1 chans start (R4 ch1 idle)", 32'(chan_start), 32'h05);
        check("R5", "pending cleared", 32'(gsw_pending), 0);
        @(negedge clk);
        check("R5", "start one cycle", 32'(chan_start), 0);
        bus_wr(32'h0000_0000);
        gsw_set = 1'b1;
        @(negedge clk);
        gsw_set = 1'b0;
        @(negedge clk);
        check("R5", "pending clears with no code1", 32'(gsw_pending), 0);
    endtask

    task automatic t_level();
        bus_wr(32'h0002_0002);
        lsw_level = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6", "level held", 32'(chan_start), 32'h11);
        end
        lsw_level = 1'b0;
        @(negedge clk);
        check("R6", "level released", 32'(chan_start), 0);
    endtask

    task automatic t_scan();
        bus_wr(32'h0333_3333);
        scan_mask = 7'h55;
        scan_trig = 1'b1;
        @(negedge clk);
        check("R7", "masked scan", 32'(chan_start), 32'h55);
        @(negedge clk);
        check("R11", "scan held no repeat", 32'(chan_start), 0);
        scan_trig = 1'b0;
    endtask

    task automatic t_sync();
        bus_wr(32'h0440_0000);
        sync_trig = 1'b1;
        @(negedge clk);
        check("R8", "sync edge", 32'(chan_start), 32'h60);
        @(negedge clk);
        check("R11", "sync held no repeat", 32'(chan_start), 0);
        sync_trig = 1'b0;
    endtask

    task automatic t_event();
        bus_wr(32'h0BA9_8765);
        event_start_en = 1'b1;
        evt_in = 11'h004;
        @(negedge clk);
        check("R9", "evt2 to ch2", 32'(chan_start), 32'h04);
        @(negedge clk);
        check("R11", "evt held no repeat", 32'(chan_start), 0);
        evt_in = 11'h000;
        @(negedge clk);
        evt_in = 11'h7FF;
        @(negedge clk);
        check("R9", "all events", 32'(chan_start), 32'h7F);
        evt_in = 11'h000;
        event_start_en = 1'b0;
        @(negedge clk);
        evt_in = 11'h7FF;
        @(negedge clk);
        check("R9", "events gated off", 32'(chan_start), 0);
        evt_in = 11'h000;
        bus_wr(32'h0000_F000);
        event_start_en = 1'b1;
        evt_in = 11'h200;
        @(negedge clk);
        check("R9", "evt9 not code15", 32'(chan_start), 0);
        evt_in = 11'h400;
        @(negedge clk);
        check("R9", "evt10 code15 ch3", 32'(chan_start), 32'h08);
        evt_in = 11'h000;
        event_start_en = 1'b0;
    endtask

    task automatic t_override();
        bus_wr(32'h0000_0042);
        sw_conv_en = 1'b1;
        core_sel = 2'd1;
        lsw_level = 1'b1;
        sync_trig = 1'b1;
        @(negedge clk);
        check("R10", "override blocks", 32'(chan_start), 0);
        core_sel = 2'd2;
        @(negedge clk);
        check("R10", "other core_sel routes", 32'(chan_start), 32'h01);
        lsw_level = 1'b0;
        sync_trig = 1'b0;
        sw_conv_en = 1'b0;
        core_sel = 2'd0;
        @(negedge clk);
    endtask

    task automatic t_collide();
        bus_wr(32'h0000_0000);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_wdata = 32'h0000_0004;
        sync_trig = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R12", "old selector used", 32'(chan_start), 0);
        check("R12", "new word stored", bus_rdata, 32'h4);
        @(negedge clk);
        check("R12", "edge consumed", 32'(chan_start), 0);
        sync_trig = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_locked();
        t_gsw();
        t_level();
        t_scan();
        t_sync();
        t_event();
        t_override();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule